// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This host-side controller runs complete erase and program jobs against a byte-wide flash part. The flash sits on a simple synchronous bus made of a chip select, a read strobe, a write strobe, an address and data in each direction. A request names either a sector to erase or a starting address and a byte count to program. Program bytes are pulled one at a time from a valid/ready data port. Every job starts by lifting the part's software write protection. The job then issues the two-write command for each step and waits for the part's internal write to finish. After each step it reads the result back to confirm it.

Read data on the flash bus is valid in the cycle after the read strobe. The end of each internal write is found in one of three ways, picked per request: bit 7 of a read matching the expected data, bit 6 no longer toggling, or two identical reads in a row. A per-step cycle limit stops a write that never finishes. When a job ends, the block gives one completion pulse, an error flag and the address of the first failure.

Top module: `fps_seq`

## Requirements
- R1: Every accepted request begins with exactly seven flash reads at addresses 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h, 041Ah, in that order and with address bits 18..16 at zero. No flash write of that request comes before the seventh of these reads.
- R2: A sector erase writes 20h and then D0h, both at the sector base, which is the request address with bits 7..0 cleared. Exactly two writes are issued when the erase succeeds.
- R3: After an erase step finishes, the 256 bytes of the sector are read in ascending order. The first byte not equal to FFh ends the job with err_o high and err_addr_o set to that byte's address. If all 256 bytes read FFh, the job ends with err_o low.
- R4: A program job handles req_cnt_i+1 bytes at ascending addresses from req_addr_i. For each byte, one byte is taken from the data port (data_ready_o is high only while the block waits for it), then 10h is written at the target address, then the byte itself is written at that address.
- R5: After each byte is programmed, the target address is read back. A mismatch ends the job with err_o high and err_addr_o set to that address, and no further bytes are taken or written.
- R6: With req_mode_i = 0, a write step counts as finished when bit 7 of a read of the target equals bit 7 of the expected byte (FFh for erase).
- R7: With req_mode_i = 1, a write step counts as finished when two consecutive polling reads return the same bit 6.
- R8: With req_mode_i = 2 or 3, a write step counts as finished when two consecutive polling reads return identical bytes.
- R9: If a step has not finished within ERASE_TO_CYC cycles (erase) or PROG_TO_CYC cycles (program), the block writes FFh at the step's target address (the sector base for an erase). The job then ends with err_o high and err_addr_o set to that target.
- R10: req_ready_o is high only while idle, and a request is taken only then; req_valid_i during a job has no effect. done_o is a single-cycle pulse, and err_o is high only together with done_o.
- R11: Out of reset, req_ready_o is high, and fl_cs_o, data_ready_o and done_o are low. The flash read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Idle, request accepted this cycle if valid |
| req_erase_i | input | 1 | 1 = sector erase, 0 = byte program |
| req_mode_i | input | 2 | End-of-write method: 0 bit-7 poll, 1 bit-6 toggle, 2/3 matching reads |
| req_addr_i | input | 19 | Start address (any address inside the sector for erase) |
| req_cnt_i | input | 8 | Program byte count minus one |
| data_valid_i | input | 1 | Program byte available |
| data_i | input | 8 | Program byte |
| data_ready_o | output | 1 | Block waits for the next program byte |
| fl_cs_o | output | 1 | Flash chip select |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_wr_o | output | 1 | Flash write strobe |
| fl_addr_o | output | 19 | Flash address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_rdata_i | input | 8 | Flash read data, valid the cycle after fl_rd_o |
| done_o | output | 1 | Job complete pulse |
| err_o | output | 1 | Job failed, valid with done_o |
| err_addr_o | output | 19 | First failing address |

## Verification
The bound checker watches every cycle for writes issued before the seven unprotect reads of the current job and for read and write strobes that overlap. It also checks the completion pulse and error qualification, that an abort write leads straight to an error completion, and that program data is never requested while idle. Only the bench scenarios, run against a behavioural flash model with busy timing, protection state and injectable faults, can show the exact command addresses and bytes. The same holds for the three completion methods waiting for real readiness, which byte an erase or program failure reports, the timeout abort, and that requests sent during a job are ignored.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNLK, ST_DWAIT, ST_CMD1, ST_CMD2, ST_PRD,
    ST_PCHK, ST_ABORT, ST_VRD, ST_VCHK, ST_FIN
  } fps_state_e;

  localparam logic [1:0] MODE_DPOLL  = 2'd0;
  localparam logic [1:0] MODE_TOGGLE = 2'd1;

  localparam logic [7:0] CMD_ERS_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERS_GO    = 8'hD0;
  localparam logic [7:0] CMD_PRG_SETUP = 8'h10;
  localparam logic [7:0] CMD_ABORT     = 8'hFF;
  localparam logic [7:0] BYTE_ERASED   = 8'hFF;

  localparam int UNLK_LEN = 7;

  function automatic logic [15:0] unlk_addr(input logic [2:0] idx);
    case (idx)
      3'd0:    return 16'h1823;
      3'd1:    return 16'h1820;
      3'd2:    return 16'h1822;
      3'd3:    return 16'h0418;
      3'd4:    return 16'h041B;
      3'd5:    return 16'h0419;
      default: return 16'h041A;
    endcase
  endfunction

endpackage

// File: rtl/fps_eow.sv
module fps_eow
  import fps_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          smp_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] exp_i,
  input  logic [DW-1:0] rdata_i,
  output logic          hit_o
);
  logic [DW-1:0] prev_q;
  logic          prev_vld_q;

  always_comb begin
    case (mode_i)
      MODE_DPOLL:  hit_o = (rdata_i[DW-1] == exp_i[DW-1]);
      MODE_TOGGLE: hit_o = prev_vld_q && (prev_q[DW-2] == rdata_i[DW-2]);
      default:     hit_o = prev_vld_q && (prev_q == rdata_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (clr_i) begin
      prev_vld_q <= 1'b0;
    end else if (smp_i) begin
      prev_q     <= rdata_i;
      prev_vld_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fps_tmo.sv
module fps_tmo #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] lim_i,
  output logic         exp_o
);
  logic [W-1:0] cnt_q;

  assign exp_o = (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && !exp_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fps_seq.sv
module fps_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int SECT_W       = 8,
  parameter int CNT_W        = 8,
  parameter int ERASE_TO_CYC = 800000,
  parameter int PROG_TO_CYC  = 8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_erase_i,
  input  logic [1:0]        req_mode_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  req_cnt_i,
  input  logic              data_valid_i,
  input  logic [7:0]        data_i,
  output logic              data_ready_o,
  output logic              fl_cs_o,
  output logic              fl_rd_o,
  output logic              fl_wr_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  input  logic [7:0]        fl_rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] err_addr_o
);
  localparam int TO_MAX = (ERASE_TO_CYC > PROG_TO_CYC) ? ERASE_TO_CYC : PROG_TO_CYC;
  localparam int TO_W   = $clog2(TO_MAX + 1);
  localparam logic [2:0] UNLK_LAST = 3'(UNLK_LEN - 1);

  fps_state_e        state_q;
  logic              erase_q;
  logic [1:0]        mode_q;
  logic [CNT_W-1:0]  rem_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic [7:0]        wbyte_q;
  logic [2:0]        uidx_q;
  logic              err_q;
  logic [ADDR_W-1:0] err_addr_q;

  logic [7:0]        exp_byte;
  logic              eow_hit;
  logic              tmo_exp;
  logic [TO_W-1:0]   tmo_lim;

  assign exp_byte = erase_q ? BYTE_ERASED : wbyte_q;
  assign tmo_lim  = erase_q ? TO_W'(ERASE_TO_CYC) : TO_W'(PROG_TO_CYC);

  fps_eow #(.DW(8)) u_eow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == ST_CMD2),
    .smp_i   (state_q == ST_PCHK),
    .mode_i  (mode_q),
    .exp_i   (exp_byte),
    .rdata_i (fl_rdata_i),
    .hit_o   (eow_hit)
  );

  fps_tmo #(.W(TO_W)) u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_CMD2),
    .run_i  ((state_q == ST_PRD) || (state_q == ST_PCHK)),
    .lim_i  (tmo_lim),
    .exp_o  (tmo_exp)
  );

  // bus decode from state only
  always_comb begin
    fl_rd_o    = 1'b0;
    fl_wr_o    = 1'b0;
    fl_addr_o  = tgt_q;
    fl_wdata_o = 8'h00;
    case (state_q)
      ST_UNLK: begin
        fl_rd_o   = 1'b1;
        fl_addr_o = ADDR_W'(unlk_addr(uidx_q));
      end
      ST_CMD1: begin
        fl_wr_o    = 1'b1;
        fl_wdata_o = erase_q ? CMD_ERS_SETUP : CMD_PRG_SETUP;
      end
      ST_CMD2: begin
        fl_wr_o    = 1'b1;
        fl_wdata_o = erase_q ? CMD_ERS_GO : wbyte_q;
      end
      ST_PRD:   fl_rd_o = 1'b1;
      ST_ABORT: begin
        fl_wr_o    = 1'b1;
        fl_wdata_o = CMD_ABORT;
      end
      ST_VRD: begin
        fl_rd_o   = 1'b1;
        fl_addr_o = vaddr_q;
      end
      default: ;
    endcase
  end

  assign fl_cs_o      = fl_rd_o | fl_wr_o;
  assign req_ready_o  = (state_q == ST_IDLE);
  assign data_ready_o = (state_q == ST_DWAIT);
  assign done_o       = (state_q == ST_FIN);
  assign err_o        = (state_q == ST_FIN) && err_q;
  assign err_addr_o   = err_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      erase_q    <= 1'b0;
      mode_q     <= MODE_DPOLL;
      rem_q      <= '0;
      tgt_q      <= '0;
      vaddr_q    <= '0;
      wbyte_q    <= '0;
      uidx_q     <= '0;
      err_q      <= 1'b0;
      err_addr_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          erase_q    <= req_erase_i;
          mode_q     <= req_mode_i;
          rem_q      <= req_cnt_i;
          tgt_q      <= req_erase_i ? {req_addr_i[ADDR_W-1:SECT_W], SECT_W'(0)} : req_addr_i;
          err_q      <= 1'b0;
          err_addr_q <= '0;
          uidx_q     <= '0;
          state_q    <= ST_UNLK;
        end
        ST_UNLK: begin
          if (uidx_q == UNLK_LAST) state_q <= erase_q ? ST_CMD1 : ST_DWAIT;
          else                     uidx_q  <= uidx_q + 3'd1;
        end
        ST_DWAIT: if (data_valid_i) begin
          wbyte_q <= data_i;
          state_q <= ST_CMD1;
        end
        ST_CMD1: state_q <= ST_CMD2;
        ST_CMD2: begin
          vaddr_q <= tgt_q;
          state_q <= ST_PRD;
        end
        ST_PRD: state_q <= ST_PCHK;
        ST_PCHK: begin
          if (eow_hit)      state_q <= ST_VRD;
          else if (tmo_exp) state_q <= ST_ABORT;
          else              state_q <= ST_PRD;
        end
        ST_ABORT: begin
          err_q      <= 1'b1;
          err_addr_q <= tgt_q;
          state_q    <= ST_FIN;
        end
        ST_VRD: state_q <= ST_VCHK;
        ST_VCHK: begin
          if (fl_rdata_i != exp_byte) begin
            err_q      <= 1'b1;
            err_addr_q <= vaddr_q;
            state_q    <= ST_FIN;
          end else if (erase_q) begin
            if (&vaddr_q[SECT_W-1:0]) state_q <= ST_FIN;
            else begin
              vaddr_q <= vaddr_q + 1'b1;
              state_q <= ST_VRD;
            end
          end else if (rem_q == '0) begin
            state_q <= ST_FIN;
          end else begin
            rem_q   <= rem_q - 1'b1;
            tgt_q   <= tgt_q + 1'b1;
            state_q <= ST_DWAIT;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fps_seq_chk.sv
module fps_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       data_ready_o,
  input logic       fl_rd_o,
  input logic       fl_wr_o,
  input logic [7:0] fl_wdata_o,
  input logic       done_o,
  input logic       err_o
);
  logic [2:0] unl_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           unl_cnt_q <= '0;
    else if (req_valid_i && req_ready_o)   unl_cnt_q <= '0;
    else if (fl_rd_o && unl_cnt_q != 3'd7) unl_cnt_q <= unl_cnt_q + 3'd1;
  end

  AST_NO_WR_BEFORE_UNLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_wr_o |-> (unl_cnt_q == 3'd7)); // R1
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_rd_o && fl_wr_o)); // R11
  AST_DATA_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> !req_ready_o); // R4
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o); // R10
  AST_ABORT_ENDS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_wr_o && fl_wdata_o == 8'hFF && !$past(fl_wr_o)) |=> (done_o && err_o)); // R9
endmodule

bind fps_seq fps_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .data_ready_o (data_ready_o),
  .fl_rd_o      (fl_rd_o),
  .fl_wr_o      (fl_wr_o),
  .fl_wdata_o   (fl_wdata_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/fps_seq_tb.sv
`timescale 1ns/1ps
module fps_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_erase_i = 1'b0;
  logic [1:0]  req_mode_i = 2'd0;
  logic [18:0] req_addr_i = '0;
  logic [7:0]  req_cnt_i = '0;
  logic        data_valid_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic        data_ready_o;
  logic        fl_cs_o, fl_rd_o, fl_wr_o;
  logic [18:0] fl_addr_o;
  logic [7:0]  fl_wdata_o;
  logic [7:0]  fl_rdata_i = '0;
  logic        done_o, err_o;
  logic [18:0] err_addr_o;

  always #2.5 clk_i = ~clk_i;

  fps_seq #(.ERASE_TO_CYC(400), .PROG_TO_CYC(60)) dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_erase_i, .req_mode_i,
    .req_addr_i, .req_cnt_i, .data_valid_i, .data_i, .data_ready_o,
    .fl_cs_o, .fl_rd_o, .fl_wr_o, .fl_addr_o, .fl_wdata_o, .fl_rdata_i,
    .done_o, .err_o, .err_addr_o
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // ---------------- flash model (acts on the falling edge) ----------------
  logic [7:0] mem [1024];
  bit         prot = 1'b1;
  bit         busy = 1'b0;
  bit         hang = 1'b0;
  bit         b_erase;
  int         bcnt;
  int         bidx;
  logic [7:0] bexp;
  bit         tog = 1'b0;
  int         cmd = 0;
  int         uidx = 0;
  int         erase_stuck = -1;
  int         prog_stuck = -1;

  function automatic logic [15:0] seq_addr(int i);
    case (i)
      0: return 16'h1823; 1: return 16'h1820; 2: return 16'h1822;
      3: return 16'h0418; 4: return 16'h041B; 5: return 16'h0419;
      default: return 16'h041A;
    endcase
  endfunction

  always @(negedge clk_i) begin
    if (busy && !hang) begin
      if (bcnt <= 1) begin
        busy = 1'b0;
        if (b_erase) begin
          for (int k = 0; k < 256; k++)
            if ((bidx + k) != erase_stuck) mem[bidx + k] = 8'hFF;
        end else begin
          mem[bidx] = mem[bidx] & bexp & ((bidx == prog_stuck) ? 8'hFE : 8'hFF);
        end
      end else bcnt--;
    end
    if (fl_cs_o && fl_rd_o) begin
      if (busy) begin
        fl_rdata_i = {~bexp[7], tog, bexp[5:0]};
        tog = ~tog;
      end else fl_rdata_i = mem[fl_addr_o[9:0]];
      if (fl_addr_o[15:0] == seq_addr(uidx)) uidx++;
      else if (fl_addr_o[15:0] == seq_addr(0)) uidx = 1;
      else uidx = 0;
      if (uidx == 7) begin prot = 1'b0; uidx = 0; end
    end
    if (fl_cs_o && fl_wr_o) begin
      if (busy) begin
        if (fl_wdata_o == 8'hFF) busy = 1'b0;
      end else if (!prot) begin
        if (cmd == 0) begin
          if (fl_wdata_o == 8'h20) cmd = 1;
          else if (fl_wdata_o == 8'h10) cmd = 2;
        end else if (cmd == 1) begin
          if (fl_wdata_o == 8'hD0) begin
            busy = 1'b1; b_erase = 1'b1; bcnt = 100;
            bidx = int'({fl_addr_o[9:8], 8'h00}); bexp = 8'hFF;
          end
          cmd = 0;
        end else begin
          busy = 1'b1; b_erase = 1'b0; bcnt = 20;
          bidx = int'(fl_addr_o[9:0]); bexp = fl_wdata_o;
          cmd = 0;
        end
      end
    end
  end

  // ---------------- bus monitor ----------------
  logic [18:0] rd_hist [7];
  logic [18:0] wr_a [64];
  logic [7:0]  wr_d [64];
  bit          wr_unl [64];
  int          wr_cnt = 0;
  int          both_cnt = 0;

  always @(negedge clk_i) begin
    if (fl_rd_o && fl_wr_o) both_cnt++;
    if (fl_wr_o) begin
      bit ok;
      ok = 1'b1;
      for (int k = 0; k < 7; k++)
        if (rd_hist[k] != {3'b000, seq_addr(k)}) ok = 1'b0;
      wr_a[wr_cnt % 64]   = fl_addr_o;
      wr_d[wr_cnt % 64]   = fl_wdata_o;
      wr_unl[wr_cnt % 64] = ok;
      wr_cnt++;
    end
    if (fl_rd_o) begin
      for (int k = 0; k < 6; k++) rd_hist[k] = rd_hist[k+1];
      rd_hist[6] = fl_addr_o;
    end
  end

  // ---------------- helpers ----------------
  logic [7:0] feed_buf [16];
  int         feed_n;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // intrude: send an erase request of sector 2 while the job runs
  task automatic run_op(input bit er, input logic [18:0] a, input logic [7:0] cnt_m1,
                        input logic [1:0] md, input bit intrude,
                        output bit got_err, output logic [18:0] got_addr, output int w0);
    int fi;
    bit seen;
    fi = 0; seen = 1'b0; got_err = 1'b0; got_addr = '0;
    @(negedge clk_i);
    w0 = wr_cnt;
    req_erase_i = er; req_addr_i = a; req_cnt_i = cnt_m1; req_mode_i = md;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      if (intrude && c == 10) begin
        chk(req_ready_o == 1'b0, "R10 ready low while busy", 32'(req_ready_o), 0);
        req_erase_i = 1'b1; req_addr_i = 19'h00200; req_valid_i = 1'b1;
      end
      if (intrude && c == 14) req_valid_i = 1'b0;
      if (data_valid_i && !data_ready_o) begin data_valid_i = 1'b0; fi++; end
      if (data_ready_o && !data_valid_i && fi < feed_n) begin
        data_valid_i = 1'b1; data_i = feed_buf[fi];
      end
      if (done_o) begin
        seen = 1'b1; got_err = err_o; got_addr = err_addr_o;
        break;
      end
      @(negedge clk_i);
    end
    data_valid_i = 1'b0;
    req_valid_i = 1'b0;
    chk(seen, "R10 done seen", 32'(seen), 1);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R10 done single cycle", 32'(done_o), 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(req_ready_o == 1'b1, "R11 ready after reset", 32'(req_ready_o), 1);
    chk(fl_cs_o == 1'b0, "R11 cs low after reset", 32'(fl_cs_o), 0);
    chk(done_o == 1'b0 && data_ready_o == 1'b0, "R11 done/data_ready low",
        32'({done_o, data_ready_o}), 0);
  endtask

  task automatic t_erase_ok();
    bit e; logic [18:0] ea; int w0; int bad;
    prot = 1'b1;
    run_op(1'b1, 19'h00135, 8'd0, 2'd0, 1'b0, e, ea, w0);
    chk(e == 1'b0, "R3 erase ok no error", 32'(e), 0);
    bad = 0;
    for (int k = 256; k < 512; k++) if (mem[k] != 8'hFF) bad++;
    chk(bad == 0, "R3 sector erased", 32'(bad), 0);
    chk(wr_unl[w0 % 64], "R1 unprotect before erase setup", 32'(wr_unl[w0 % 64]), 1);
    chk(wr_a[w0 % 64] == 19'h00100 && wr_d[w0 % 64] == 8'h20, "R2 erase setup",
        {5'd0, wr_a[w0 % 64], wr_d[w0 % 64]}, {5'd0, 19'h00100, 8'h20});
    chk(wr_a[(w0+1) % 64] == 19'h00100 && wr_d[(w0+1) % 64] == 8'hD0, "R2 erase go",
        {5'd0, wr_a[(w0+1) % 64], wr_d[(w0+1) % 64]}, {5'd0, 19'h00100, 8'hD0});
    chk(wr_cnt - w0 == 2, "R2 two writes", 32'(wr_cnt - w0), 2);
  endtask

  task automatic t_prog(input logic [18:0] a, input int n, input logic [1:0] md, input string tag);
    bit e; logic [18:0] ea; int w0;
    prot = 1'b1;
    run_op(1'b0, a, 8'(n - 1), md, 1'b0, e, ea, w0);
    chk(e == 1'b0, tag, 32'(e), 0);
    chk(wr_unl[w0 % 64], "R1 unprotect before program", 32'(wr_unl[w0 % 64]), 1);
    for (int k = 0; k < n; k++) begin
      chk(mem[a[9:0] + k] == feed_buf[k], tag, 32'(mem[a[9:0] + k]), 32'(feed_buf[k]));
      chk(wr_d[(w0 + 2*k) % 64] == 8'h10 && wr_a[(w0 + 2*k + 1) % 64] == a + 19'(k)
          && wr_d[(w0 + 2*k + 1) % 64] == feed_buf[k], "R4 setup then data at address",
          {5'd0, wr_a[(w0 + 2*k + 1) % 64], wr_d[(w0 + 2*k + 1) % 64]},
          {5'd0, a + 19'(k), feed_buf[k]});
    end
  endtask

  task automatic t_prog_fail();
    bit e; logic [18:0] ea; int w0;
    prot = 1'b1; prog_stuck = 32'h202;
    feed_buf[0] = 8'h10; feed_buf[1] = 8'h20; feed_buf[2] = 8'h01;
    feed_buf[3] = 8'h40; feed_buf[4] = 8'h50; feed_n = 5;
    run_op(1'b0, 19'h00200, 8'd4, 2'd0, 1'b0, e, ea, w0);
    chk(e == 1'b1, "R5 program mismatch flagged", 32'(e), 1);
    chk(ea == 19'h00202, "R5 failing address", 32'(ea), 32'h202);
    chk(mem[10'h201] == 8'h20, "R5 earlier byte kept", 32'(mem[10'h201]), 32'h20);
    chk(mem[10'h203] == 8'hFF, "R5 later byte not written", 32'(mem[10'h203]), 32'hFF);
    prog_stuck = -1;
  endtask

  task automatic t_erase_fail();
    bit e; logic [18:0] ea; int w0;
    prot = 1'b1;
    mem[10'h3A0] = 8'h00; mem[10'h3A7] = 8'h12; erase_stuck = 32'h3A7;
    run_op(1'b1, 19'h003FF, 8'd0, 2'd2, 1'b0, e, ea, w0);
    chk(e == 1'b1, "R3 erase verify flagged", 32'(e), 1);
    chk(ea == 19'h003A7, "R3 erase failing address", 32'(ea), 32'h3A7);
    chk(mem[10'h3A0] == 8'hFF, "R3 other bytes erased", 32'(mem[10'h3A0]), 32'hFF);
    erase_stuck = -1; mem[10'h3A7] = 8'hFF;
  endtask

  task automatic t_timeout();
    bit e; logic [18:0] ea; int w0; int lw;
    prot = 1'b1; hang = 1'b1;
    feed_buf[0] = 8'h33; feed_n = 1;
    run_op(1'b0, 19'h00010, 8'd0, 2'd0, 1'b0, e, ea, w0);
    lw = (wr_cnt - 1) % 64;
    chk(e == 1'b1, "R9 timeout error", 32'(e), 1);
    chk(ea == 19'h00010, "R9 timeout address", 32'(ea), 32'h10);
    chk(wr_a[lw] == 19'h00010 && wr_d[lw] == 8'hFF, "R9 abort write FF at target",
        {5'd0, wr_a[lw], wr_d[lw]}, {5'd0, 19'h00010, 8'hFF});
    chk(wr_cnt - w0 == 3, "R9 three writes", 32'(wr_cnt - w0), 3);
    hang = 1'b0;
  endtask

  task automatic t_ignore();
    bit e; logic [18:0] ea; int w0; int extra;
    prot = 1'b1;
    feed_buf[0] = 8'h99; feed_n = 1;
    run_op(1'b0, 19'h00300, 8'd0, 2'd0, 1'b1, e, ea, w0);
    chk(e == 1'b0 && mem[10'h300] == 8'h99, "R10 job completes", 32'(mem[10'h300]), 32'h99);
    extra = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk_i);
      if (done_o) extra++;
    end
    chk(extra == 0, "R10 no second job", 32'(extra), 0);
    chk(mem[10'h200] == 8'h10, "R10 request during job ignored", 32'(mem[10'h200]), 32'h10);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles >= 190000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<190000", cycles);
        summary();
      end
    end
  end

  initial begin
    for (int k = 0; k < 1024; k++) mem[k] = 8'hFF;
    for (int k = 0; k < 256; k++) mem[256 + k] = 8'(k) ^ 8'h5A;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_erase_ok();
    feed_buf[0] = 8'hA5; feed_buf[1] = 8'h3C; feed_buf[2] = 8'h00; feed_buf[3] = 8'h81; feed_n = 4;
    t_prog(19'h00105, 4, 2'd1, "R7 toggle mode program");
    feed_buf[0] = 8'h7E; feed_buf[1] = 8'hC3; feed_n = 2;
    t_prog(19'h00150, 2, 2'd0, "R6 data poll program");
    feed_buf[0] = 8'h11; feed_buf[1] = 8'h80; feed_buf[2] = 8'h6F; feed_n = 3;
    t_prog(19'h00160, 3, 2'd2, "R8 matching reads program");
    feed_buf[0] = 8'h42; feed_n = 1;
    t_prog(19'h00170, 1, 2'd3, "R8 mode 3 program");
    t_prog_fail();
    t_erase_fail();
    t_timeout();
    t_ignore();
    chk(both_cnt == 0, "R11 rd and wr never together", 32'(both_cnt), 0);
    summary();
  end
endmodule